// File: doc/BRIEF.md
# Region Record Serializer

This block sits at the edge of an array of four-pixel readout regions and turns one region's triggered event into a 32-bit serial record. Each region reports whether it holds a triggered event, along with the ToT value and neighbour bit of each of its four pixels and the trigger ID of the event. After a trigger has been seen, the block raises a token line. This line tells the off-chip controller that data are waiting.

The controller then pulses a read line. The block chooses the lowest-numbered pending region and latches its record. It sends a one-cycle acknowledge to that region so the event storage can release the event. It then shifts the record out on a single data line, one bit per cycle of the externally supplied output clock. The record has no header, framing or coding.

All inputs, including read, trigger and trigger request, are synchronous to the output clock. The reset is active low and asynchronous.

Top module: `rro_serializer`

## Requirements
- R1: The record is 32 bits. Bits 31..12 hold four pixel fields of 5 bits each, with pixel 0 in bits 31..27 and pixel 3 in bits 16..12. Each field is {ToT[3:0], neighbour}. Bits 11..4 hold the region address, which equals the region index. Bits 3..0 hold the region's trigger ID.
- R2: The record leaves on `sdata` most significant bit first, one bit per clock. Bit 31 appears in the cycle after the clock edge that accepts the read, and the other 31 bits follow on consecutive cycles.
- R3: When several regions are pending, the record comes from the pending region with the lowest index.
- R4: In the cycle after an accepted read, `rd_ack` carries a single-cycle one-hot pulse on the bit of the selected region. At all other times `rd_ack` is zero.
- R5: `token` rises one cycle after a `trigger` pulse, provided that at the same clock edge `trigger_req` is high and at least one region is pending. `token` stays high while both of those conditions hold. A trigger pulse while `trigger_req` is low does not raise `token`.
- R6: `token` falls in the cycle after an edge at which either no region is pending or `trigger_req` is low.
- R7: A read sampled while a record is still shifting is ignored. It produces no acknowledge and leaves the bit stream in progress unchanged.
- R8: A read sampled while `token` is low is ignored. It produces no acknowledge and `sdata` stays low.
- R9: After reset, `token`, `sdata` and `rd_ack` are all low. `sdata` is also low whenever no record is shifting.
- R10: A region becoming pending without a trigger pulse does not raise `token`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| out_clk | input | 1 | Externally supplied output clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| read | input | 1 | Read request from the controller |
| trigger | input | 1 | Trigger pulse; arms the token |
| trigger_req | input | 1 | Level that enables token reporting |
| reg_pending | input | NREG | Per-region flag: a triggered event is held |
| reg_tot | input | NREG*NPIX*TOT_W | ToT values; region r pixel p at bits (r*NPIX+p)*TOT_W upward |
| reg_nbr | input | NREG*NPIX | Neighbour bits; region r pixel p at bit r*NPIX+p |
| reg_tid | input | NREG*TID_W | Trigger ID of each region's event |
| rd_ack | output | NREG | One-cycle release pulse to the region that was read |
| token | output | 1 | Data available |
| sdata | output | 1 | Serial record data |

## Verification
The hardest situation to reach from the ports is a read that arrives in the middle of a record while another region is still pending and the token is high. In that situation a careless design would either restart the shift or acknowledge a second region. The bench reaches it by making all sixteen regions pending and starting a read. At the tenth shifted bit it raises read again, then checks that `rd_ack` stays zero and that the full 32-bit word collected is still region 0's record. Priority is covered by table vectors with pending masks in which the lowest set bit is at 0, 4, 5, 10 and 15. The token's dependence on trigger arming is exercised by making regions pending before any trigger and by pulsing trigger while `trigger_req` is low.

// File: rtl/rro_pkg.sv
package rro_pkg;
   typedef enum logic {ST_IDLE = 1'b0, ST_SHIFT = 1'b1} rro_state_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rro_pick.sv
module rro_pick #(
   parameter int N  = 16,
   parameter int IW = 4
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  onehot
);
   always_comb begin
      found  = 1'b0;
      idx    = '0;
      onehot = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
      if (found) onehot[idx] = 1'b1;
   end
endmodule

// File: rtl/rro_pack.sv
module rro_pack #(
   parameter int NREG   = 16,
   parameter int NPIX   = 4,
   parameter int TOT_W  = 4,
   parameter int TID_W  = 4,
   parameter int ADDR_W = 8,
   parameter int IW     = 4,
   localparam int PF    = TOT_W + 1,
   localparam int REC_W = NPIX * PF + ADDR_W + TID_W
) (
   input  logic [NREG*NPIX*TOT_W-1:0] tot_flat,
   input  logic [NREG*NPIX-1:0]       nbr_flat,
   input  logic [NREG*TID_W-1:0]      tid_flat,
   input  logic [IW-1:0]              sel,
   output logic [REC_W-1:0]           rec
);
   always_comb begin
      int s;
      s   = int'(sel);
      rec = '0;
      for (int p = 0; p < NPIX; p++) begin
         rec[REC_W-1-p*PF -: PF] = {tot_flat[(s*NPIX+p)*TOT_W +: TOT_W],
                                    nbr_flat[s*NPIX+p]};
      end
      rec[TID_W +: ADDR_W] = ADDR_W'(sel);
      rec[0 +: TID_W]      = tid_flat[s*TID_W +: TID_W];
   end
endmodule

// File: rtl/rro_piso.sv
module rro_piso
   import rro_pkg::*;
#(
   parameter int W         = 32,
   parameter bit MSB_FIRST = 1'b1,
   localparam int CW       = $clog2(W + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic         busy,
   output logic         dout
);
   rro_state_e    st_q;
   logic [CW-1:0] cnt_q;
   logic [W-1:0]  sh_q;
   logic [W-1:0]  sh_next;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sh_next = {sh_q[W-2:0], 1'b0};
         assign dout    = sh_q[W-1];
      end else begin : g_lsb
         assign sh_next = {1'b0, sh_q[W-1:1]};
         assign dout    = sh_q[0];
      end
   endgenerate

   assign busy = (st_q == ST_SHIFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (load) begin
         st_q  <= ST_SHIFT;
         cnt_q <= CW'(W - 1);
         sh_q  <= din;
      end else if (st_q == ST_SHIFT) begin
         sh_q <= sh_next;
         if (cnt_q == '0) st_q  <= ST_IDLE;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/rro_serializer.sv
module rro_serializer
   import rro_pkg::*;
#(
   parameter int NREG      = 16,
   parameter int NPIX      = 4,
   parameter int TOT_W     = 4,
   parameter int TID_W     = 4,
   parameter int ADDR_W    = 8,
   parameter bit MSB_FIRST = 1'b1,
   localparam int IW       = idx_width(NREG),
   localparam int REC_W    = NPIX * (TOT_W + 1) + ADDR_W + TID_W
) (
   input  logic                        out_clk,
   input  logic                        rst_n,
   input  logic                        read,
   input  logic                        trigger,
   input  logic                        trigger_req,
   input  logic [NREG-1:0]             reg_pending,
   input  logic [NREG*NPIX*TOT_W-1:0]  reg_tot,
   input  logic [NREG*NPIX-1:0]        reg_nbr,
   input  logic [NREG*TID_W-1:0]       reg_tid,
   output logic [NREG-1:0]             rd_ack,
   output logic                        token,
   output logic                        sdata
);
   generate
      if (NREG < 1 || NPIX < 1 || TOT_W < 1 || TID_W < 1)
         $error("rro_serializer: widths and counts must be positive");
      if (ADDR_W < IW)
         $error("rro_serializer: ADDR_W too small for NREG regions");
      if (REC_W < 2)
         $error("rro_serializer: record too short");
   endgenerate

   logic            found;
   logic [IW-1:0]   sel;
   logic [NREG-1:0] sel_oh;
   logic [REC_W-1:0] rec;
   logic            busy;
   logic            accept;
   logic            token_q;
   logic [NREG-1:0] ack_q;

   rro_pick #(.N(NREG), .IW(IW)) pick_i (
      .req(reg_pending), .found(found), .idx(sel), .onehot(sel_oh)
   );

   rro_pack #(
      .NREG(NREG), .NPIX(NPIX), .TOT_W(TOT_W), .TID_W(TID_W),
      .ADDR_W(ADDR_W), .IW(IW)
   ) pack_i (
      .tot_flat(reg_tot), .nbr_flat(reg_nbr), .tid_flat(reg_tid),
      .sel(sel), .rec(rec)
   );

   assign accept = read & token_q & ~busy & found;

   rro_piso #(.W(REC_W), .MSB_FIRST(MSB_FIRST)) piso_i (
      .clk(out_clk), .rst_n(rst_n), .load(accept), .din(rec),
      .busy(busy), .dout(sdata)
   );

   always_ff @(posedge out_clk or negedge rst_n) begin
      if (!rst_n) begin
         token_q <= 1'b0;
         ack_q   <= '0;
      end else begin
         token_q <= trigger_req & (|reg_pending) & (token_q | trigger);
         ack_q   <= accept ? sel_oh : '0;
      end
   end

   assign token  = token_q;
   assign rd_ack = ack_q;
endmodule

// File: rtl/rro_serializer_chk.sv
module rro_serializer_chk #(
   parameter int NREG = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            read,
   input logic            trigger,
   input logic            trigger_req,
   input logic [NREG-1:0] reg_pending,
   input logic [NREG-1:0] rd_ack,
   input logic            token,
   input logic            sdata,
   input logic            busy
);
   AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_ack)); // R4
   AST_ACK_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (|rd_ack) |-> ($past(read) && $past(token))); // R8
   AST_BUSY_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && read) |=> (rd_ack == '0)); // R7
   AST_TOKEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_pending == '0 || !trigger_req) |=> !token); // R6
   AST_TOKEN_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (!token && !trigger) |=> !token); // R10
   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sdata); // R9
endmodule

bind rro_serializer rro_serializer_chk #(.NREG(NREG)) chk_i (
   .clk(out_clk), .rst_n(rst_n), .read(read), .trigger(trigger),
   .trigger_req(trigger_req), .reg_pending(reg_pending), .rd_ack(rd_ack),
   .token(token), .sdata(sdata), .busy(busy)
);

// File: tb/rro_serializer_tb_top.sv
module rro_serializer_tb_top;
   localparam int NREG = 16;
   localparam int NPIX = 4;

   logic                   out_clk = 1'b0;
   logic                   rst_n;
   logic                   read, trigger, trigger_req;
   logic [NREG-1:0]        reg_pending;
   logic [NREG*NPIX*4-1:0] reg_tot;
   logic [NREG*NPIX-1:0]   reg_nbr;
   logic [NREG*4-1:0]      reg_tid;
   logic [NREG-1:0]        rd_ack;
   logic                   token, sdata;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   // {pending mask, expected region, data seed}
   localparam logic [27:0] VEC [6] = '{
      {16'h0001, 4'd0,  8'h11},
      {16'h8000, 4'd15, 8'h23},
      {16'h0110, 4'd4,  8'h3a},
      {16'hFFFF, 4'd0,  8'h47},
      {16'h0C00, 4'd10, 8'h5c},
      {16'h00A0, 4'd5,  8'h6e}
   };

   rro_serializer dut_i (
      .out_clk(out_clk), .rst_n(rst_n), .read(read), .trigger(trigger),
      .trigger_req(trigger_req), .reg_pending(reg_pending),
      .reg_tot(reg_tot), .reg_nbr(reg_nbr), .reg_tid(reg_tid),
      .rd_ack(rd_ack), .token(token), .sdata(sdata)
   );

   always #10 out_clk = ~out_clk;

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] tot_of(int r, int p, int s);
      return 4'((r * 3 + p * 5 + s) & 15);
   endfunction
   function automatic logic nbr_of(int r, int p, int s);
      return 1'((r + p + s) & 1);
   endfunction
   function automatic logic [3:0] tid_of(int r, int s);
      return 4'((r ^ s) & 15);
   endfunction

   function automatic logic [31:0] exp_rec(int r, int s);
      logic [31:0] w;
      for (int p = 0; p < NPIX; p++)
         w[31-p*5 -: 5] = {tot_of(r, p, s), nbr_of(r, p, s)};
      w[11:4] = 8'(r);
      w[3:0]  = tid_of(r, s);
      return w;
   endfunction

   task automatic load_regions(int s);
      for (int r = 0; r < NREG; r++) begin
         for (int p = 0; p < NPIX; p++) begin
            reg_tot[(r*NPIX+p)*4 +: 4] = tot_of(r, p, s);
            reg_nbr[r*NPIX+p]          = nbr_of(r, p, s);
         end
         reg_tid[r*4 +: 4] = tid_of(r, s);
      end
   endtask

   task automatic pulse_trigger();
      @(negedge out_clk) trigger = 1'b1;
      @(negedge out_clk) trigger = 1'b0;
   endtask

   task automatic read_and_collect(int r, int s, bit poke);
      logic [31:0] w;
      @(negedge out_clk) read = 1'b1;
      @(negedge out_clk) read = 1'b0;
      chk(rd_ack == (NREG'(1) << r), "R4 ack of selected region",
          32'(rd_ack), 32'(NREG'(1) << r));
      reg_pending[r] = 1'b0;
      w = {31'd0, sdata};
      for (int k = 1; k < 32; k++) begin
         @(negedge out_clk);
         w = {w[30:0], sdata};
         if (poke && k == 10) read = 1'b1;
         if (poke && k == 11) begin
            read = 1'b0;
            chk(rd_ack == '0, "R7 read while shifting", 32'(rd_ack), 32'd0);
         end
      end
      chk(w == exp_rec(r, s), "R1 R2 R3 record content", w, exp_rec(r, s));
      @(negedge out_clk);
      chk(sdata == 1'b0, "R9 idle line low", 32'(sdata), 32'd0);
   endtask

   initial begin
      forever begin
         @(posedge out_clk);
         cyc++;
         if (cyc > 20000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
         end
      end
   end

   initial begin
      rst_n = 1'b0; read = 1'b0; trigger = 1'b0; trigger_req = 1'b1;
      reg_pending = '0; reg_tot = '0; reg_nbr = '0; reg_tid = '0;
      repeat (3) @(negedge out_clk);
      chk(token == 1'b0 && sdata == 1'b0 && rd_ack == '0, "R9 reset state",
          {token, sdata, 14'd0, rd_ack}, 32'd0);
      rst_n = 1'b1;

      // R10: pending without trigger
      load_regions(8'h05);
      reg_pending = 16'h0004;
      repeat (3) @(negedge out_clk);
      chk(token == 1'b0, "R10 no trigger no token", 32'(token), 32'd0);

      // R8: read while token low
      read = 1'b1;
      @(negedge out_clk) read = 1'b0;
      chk(rd_ack == '0 && sdata == 1'b0, "R8 read with token low",
          {15'd0, sdata, rd_ack}, 32'd0);
      @(negedge out_clk);
      chk(sdata == 1'b0, "R8 line stays low", 32'(sdata), 32'd0);

      // R5: trigger with trigger_req low
      trigger_req = 1'b0;
      pulse_trigger();
      chk(token == 1'b0, "R5 trigger_req low blocks token", 32'(token), 32'd0);
      trigger_req = 1'b1;
      pulse_trigger();
      chk(token == 1'b1, "R5 token after trigger", 32'(token), 32'd1);
      @(negedge out_clk) trigger_req = 1'b0;
      @(negedge out_clk);
      chk(token == 1'b0, "R6 token falls with trigger_req low", 32'(token), 32'd0);
      trigger_req = 1'b1;
      reg_pending = '0;

      // table of vectors
      for (int i = 0; i < 6; i++) begin
         reg_pending = VEC[i][27:12];
         load_regions(int'(VEC[i][7:0]));
         pulse_trigger();
         chk(token == 1'b1, "R5 token raised", 32'(token), 32'd1);
         read_and_collect(int'(VEC[i][11:8]), int'(VEC[i][7:0]), i == 3);
         if (reg_pending != '0)
            chk(token == 1'b1, "R5 token held while pending", 32'(token), 32'd1);
         reg_pending = '0;
         @(negedge out_clk);
         chk(token == 1'b0, "R6 token falls when drained", 32'(token), 32'd0);
      end

      // R3 draining two regions in order
      reg_pending = 16'h0120;
      load_regions(8'h7d);
      pulse_trigger();
      read_and_collect(5, 8'h7d, 1'b0);
      read_and_collect(8, 8'h7d, 1'b0);
      chk(token == 1'b0, "R6 token falls after last read", 32'(token), 32'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule